// File: doc/BRIEF.md
# I2C Bus Timing Count Generator

This block turns a description of an I2C bus into the integer clock-cycle counts that an I2C controller loads into its timers. The caller supplies a speed class, the period of the clock that drives the controller, the rise and fall times seen on the wires, and, if wanted, a longer SCL period. All times are in nanoseconds. The block returns ten counts: SCL high, SCL low, rise, fall, start hold, start setup, data hold, data setup, bus free and stop setup.

A per-class table of minimum times sits inside the block. A single serial divider converts every time into a cycle count, rounding up. A final stage then applies the bus rules. The high count is never below four, so that the controller can still see a target stretching the clock. The low count is its minimum. The high count takes up whatever part of the SCL period that rise, low and fall leave. The hold counts are ordered so that data hold is at least one and start hold and bus free are strictly longer than it.

The caller pulses `start`, waits for the one-cycle `done` pulse, and reads the counts. The counts hold their values until the next `done`.

Top module: `i2c_timing_calc`

## Requirements
- R1: `speed` selects the minimum table. 0 is Standard, 1 is Fast, 2 is Fast-plus, and 3 is treated as Standard. Minimums in ns, as (high, low, start hold, start setup, data hold, data setup, bus free, stop setup, SCL period):
  - Standard: 4000, 4700, 4000, 4700, 0, 250, 4700, 4000, 10000.
  - Fast: 600, 1300, 600, 600, 0, 100, 1300, 600, 2500.
  - Fast-plus: 260, 500, 260, 260, 0, 50, 500, 260, 1000.
- R2: `cnt_low`, `cnt_su_start`, `cnt_su_data` and `cnt_su_stop` each equal ceil(minimum / `tclk_ns`).
- R3: `cnt_rise` = ceil(`rise_ns` / `tclk_ns`) and `cnt_fall` = ceil(`fall_ns` / `tclk_ns`).
- R4: The working period is max(ceil(table period / `tclk_ns`), ceil(`user_period_ns` / `tclk_ns`)). A user period of 0 therefore leaves the table period in force.
- R5: `cnt_high` = max(period − rise − low − fall, max(ceil(high minimum / `tclk_ns`), 4)). The subtraction is signed, so a negative remainder yields the floor and never wraps.
- R6: `cnt_hd_data` = max(ceil(data hold minimum / `tclk_ns`), 1). `cnt_hd_start` and `cnt_bus_free` are each max(their ceil value, `cnt_hd_data` + 1).
- R7: A `start` seen while idle is accepted. `busy` is high from the next cycle until `done` is raised. `done` is a single-cycle pulse, and the count outputs change only in a cycle where `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored and produces no result. Inputs are captured only on an accepted start, so later input changes do not alter the result.
- R9: A `start` asserted in the same cycle that `done` is high is accepted and begins a new computation.
- R10: After reset, `busy`, `done` and every count output are 0.
- R11: With `NS_W` = 16, `done` rises exactly 12*(`NS_W`+3)+1 = 229 clock edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (pulse) |
| speed | input | 2 | Speed class: 0 Standard, 1 Fast, 2 Fast-plus, 3 Standard |
| tclk_ns | input | NS_W | Controller clock period in ns, nonzero |
| rise_ns | input | NS_W | Bus rise time in ns |
| fall_ns | input | NS_W | Bus fall time in ns |
| user_period_ns | input | NS_W | Requested SCL period in ns, 0 for none |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: counts are valid |
| cnt_high | output | NS_W | SCL high count |
| cnt_low | output | NS_W | SCL low count |
| cnt_rise | output | NS_W | Rise count |
| cnt_fall | output | NS_W | Fall count |
| cnt_hd_start | output | NS_W | Start hold count |
| cnt_su_start | output | NS_W | Repeated start setup count |
| cnt_hd_data | output | NS_W | Data hold count |
| cnt_su_data | output | NS_W | Data setup count |
| cnt_bus_free | output | NS_W | Bus free count |
| cnt_su_stop | output | NS_W | Stop setup count |

## Verification
The completion of one computation and the acceptance of the next can fall in the same cycle. The block drops `busy` in the cycle where it raises `done`, so a `start` seen in that cycle has to be taken.

The bench provokes this by watching for `done` and raising `start` in that very cycle, with new inputs. The scoreboard then expects two results in order: the first must carry the old inputs' counts and the second the new ones. A `start` pulsed while the block is busy, with different inputs, must produce no result at all.

// File: rtl/i2c_tc_pkg.sv
package i2c_tc_pkg;

  localparam int TAB_W = 16;
  localparam int NJOB  = 12;
  localparam int JOB_W = 4;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FPLUS = 2'd2,
    SPD_RSVD  = 2'd3
  } speed_e;

  // job order: the eight table minimums, then rise, fall, period, user period
  localparam logic [JOB_W-1:0] J_HIGH  = 4'd0;
  localparam logic [JOB_W-1:0] J_LOW   = 4'd1;
  localparam logic [JOB_W-1:0] J_HDSTA = 4'd2;
  localparam logic [JOB_W-1:0] J_SUSTA = 4'd3;
  localparam logic [JOB_W-1:0] J_HDDAT = 4'd4;
  localparam logic [JOB_W-1:0] J_SUDAT = 4'd5;
  localparam logic [JOB_W-1:0] J_BUF   = 4'd6;
  localparam logic [JOB_W-1:0] J_STO   = 4'd7;
  localparam logic [JOB_W-1:0] J_RISE  = 4'd8;
  localparam logic [JOB_W-1:0] J_FALL  = 4'd9;
  localparam logic [JOB_W-1:0] J_PER   = 4'd10;
  localparam logic [JOB_W-1:0] J_USER  = 4'd11;

  // minimum time in ns for a speed class and a job; 0 for jobs fed from ports
  function automatic logic [TAB_W-1:0] mode_min_ns(input logic [1:0] spd,
                                                   input logic [JOB_W-1:0] job);
    logic [TAB_W-1:0] v;
    v = '0;
    case (spd)
      SPD_FAST: begin
        case (job)
          J_HIGH:  v = 16'd600;
          J_LOW:   v = 16'd1300;
          J_HDSTA: v = 16'd600;
          J_SUSTA: v = 16'd600;
          J_SUDAT: v = 16'd100;
          J_BUF:   v = 16'd1300;
          J_STO:   v = 16'd600;
          J_PER:   v = 16'd2500;
          default: v = '0;
        endcase
      end
      SPD_FPLUS: begin
        case (job)
          J_HIGH:  v = 16'd260;
          J_LOW:   v = 16'd500;
          J_HDSTA: v = 16'd260;
          J_SUSTA: v = 16'd260;
          J_SUDAT: v = 16'd50;
          J_BUF:   v = 16'd500;
          J_STO:   v = 16'd260;
          J_PER:   v = 16'd1000;
          default: v = '0;
        endcase
      end
      default: begin
        case (job)
          J_HIGH:  v = 16'd4000;
          J_LOW:   v = 16'd4700;
          J_HDSTA: v = 16'd4000;
          J_SUSTA: v = 16'd4700;
          J_SUDAT: v = 16'd250;
          J_BUF:   v = 16'd4700;
          J_STO:   v = 16'd4000;
          J_PER:   v = 16'd10000;
          default: v = '0;
        endcase
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_tc_limit_rom.sv
module i2c_tc_limit_rom
  import i2c_tc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic [1:0]       spd,
  input  logic [JOB_W-1:0] job,
  output logic [DW-1:0]    data_o
);

  // synchronous read so the table can map onto a block memory
  always_ff @(posedge clk) begin
    data_o <= DW'(mode_min_ns(spd, job));
  end

endmodule

// File: rtl/i2c_tc_ceildiv.sv
module i2c_tc_ceildiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  logic [W:0]    shifted, trial;
  logic          take;
  logic [W-1:0]  rem_n, quo_n;
  logic [W:0]    rounded;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, den_q};
    take    = ~trial[W];
    rem_n   = take ? trial[W-1:0] : shifted[W-1:0];
    quo_n   = {quo_q[W-2:0], take};
    rounded = {1'b0, quo_n} + {{W{1'b0}}, (rem_n != '0)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go) begin
        den_q <= den;
        quo_q <= num;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
          quot_o <= rounded[W] ? {W{1'b1}} : rounded[W-1:0];
        end
      end
    end
  end

  // R3: the remainder left by a finished division is below the divisor
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (done_o && den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/i2c_tc_rules.sv
module i2c_tc_rules
  import i2c_tc_pkg::*;
#(
  parameter int W        = 16,
  parameter int HI_FLOOR = 4
) (
  input  logic [NJOB-1:0][W-1:0] raw,
  output logic [W-1:0]           hi,
  output logic [W-1:0]           lo,
  output logic [W-1:0]           ri,
  output logic [W-1:0]           fa,
  output logic [W-1:0]           hd_sta,
  output logic [W-1:0]           su_sta,
  output logic [W-1:0]           hd_dat,
  output logic [W-1:0]           su_dat,
  output logic [W-1:0]           bus_free,
  output logic [W-1:0]           su_sto
);

  logic [W-1:0]        hold, hold_nx, hi_floor, period;
  logic signed [W+1:0] spare, floor_s;

  always_comb begin
    hold     = (raw[J_HDDAT] == '0) ? W'(1) : raw[J_HDDAT];
    hold_nx  = hold + W'(1);
    hi_floor = (raw[J_HIGH] < W'(HI_FLOOR)) ? W'(HI_FLOOR) : raw[J_HIGH];
    period   = (raw[J_USER] > raw[J_PER]) ? raw[J_USER] : raw[J_PER];
    spare    = $signed({2'b00, period}) - $signed({2'b00, raw[J_RISE]})
             - $signed({2'b00, raw[J_LOW]}) - $signed({2'b00, raw[J_FALL]});
    floor_s  = $signed({2'b00, hi_floor});

    hi       = (spare > floor_s) ? spare[W-1:0] : hi_floor;
    lo       = raw[J_LOW];
    ri       = raw[J_RISE];
    fa       = raw[J_FALL];
    hd_dat   = hold;
    hd_sta   = (raw[J_HDSTA] > hold) ? raw[J_HDSTA] : hold_nx;
    bus_free = (raw[J_BUF] > hold) ? raw[J_BUF] : hold_nx;
    su_sta   = raw[J_SUSTA];
    su_dat   = raw[J_SUDAT];
    su_sto   = raw[J_STO];
  end

endmodule

// File: rtl/i2c_timing_calc.sv
module i2c_timing_calc
  import i2c_tc_pkg::*;
#(
  parameter int NS_W     = 16,
  parameter int HI_FLOOR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      speed,
  input  logic [NS_W-1:0] tclk_ns,
  input  logic [NS_W-1:0] rise_ns,
  input  logic [NS_W-1:0] fall_ns,
  input  logic [NS_W-1:0] user_period_ns,
  output logic            busy,
  output logic            done,
  output logic [NS_W-1:0] cnt_high,
  output logic [NS_W-1:0] cnt_low,
  output logic [NS_W-1:0] cnt_rise,
  output logic [NS_W-1:0] cnt_fall,
  output logic [NS_W-1:0] cnt_hd_start,
  output logic [NS_W-1:0] cnt_su_start,
  output logic [NS_W-1:0] cnt_hd_data,
  output logic [NS_W-1:0] cnt_su_data,
  output logic [NS_W-1:0] cnt_bus_free,
  output logic [NS_W-1:0] cnt_su_stop
);

  localparam logic [JOB_W-1:0] LAST_JOB = JOB_W'(NJOB - 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_FINAL} state_e;

  state_e                   state_q;
  logic [1:0]               spd_q;
  logic [NS_W-1:0]          tclk_q, rise_q, fall_q, user_q;
  logic [JOB_W-1:0]         job_q;
  logic [NJOB-1:0][NS_W-1:0] res_q;

  logic [NS_W-1:0] rom_data, div_num, div_quot;
  logic            div_go, div_done;

  logic [NS_W-1:0] r_hi, r_lo, r_ri, r_fa, r_hds, r_sus, r_hdd, r_sud, r_bf, r_sto;

  i2c_tc_limit_rom #(.DW(NS_W)) u_rom (
    .clk    (clk),
    .spd    (spd_q),
    .job    (job_q),
    .data_o (rom_data)
  );

  always_comb begin
    case (job_q)
      J_RISE:  div_num = rise_q;
      J_FALL:  div_num = fall_q;
      J_USER:  div_num = user_q;
      default: div_num = rom_data;
    endcase
    div_go = (state_q == S_ISSUE);
  end

  i2c_tc_ceildiv #(.W(NS_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .go     (div_go),
    .num    (div_num),
    .den    (tclk_q),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  i2c_tc_rules #(.W(NS_W), .HI_FLOOR(HI_FLOOR)) u_rules (
    .raw      (res_q),
    .hi       (r_hi),
    .lo       (r_lo),
    .ri       (r_ri),
    .fa       (r_fa),
    .hd_sta   (r_hds),
    .su_sta   (r_sus),
    .hd_dat   (r_hdd),
    .su_dat   (r_sud),
    .bus_free (r_bf),
    .su_sto   (r_sto)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      spd_q        <= '0;
      tclk_q       <= '0;
      rise_q       <= '0;
      fall_q       <= '0;
      user_q       <= '0;
      job_q        <= '0;
      res_q        <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      cnt_high     <= '0;
      cnt_low      <= '0;
      cnt_rise     <= '0;
      cnt_fall     <= '0;
      cnt_hd_start <= '0;
      cnt_su_start <= '0;
      cnt_hd_data  <= '0;
      cnt_su_data  <= '0;
      cnt_bus_free <= '0;
      cnt_su_stop  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            spd_q   <= speed;
            tclk_q  <= tclk_ns;
            rise_q  <= rise_ns;
            fall_q  <= fall_ns;
            user_q  <= user_period_ns;
            job_q   <= '0;
            busy    <= 1'b1;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: state_q <= S_ISSUE;
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (div_done) begin
            res_q[job_q] <= div_quot;
            if (job_q == LAST_JOB) begin
              state_q <= S_FINAL;
            end else begin
              job_q   <= job_q + 1'b1;
              state_q <= S_FETCH;
            end
          end
        end
        S_FINAL: begin
          cnt_high     <= r_hi;
          cnt_low      <= r_lo;
          cnt_rise     <= r_ri;
          cnt_fall     <= r_fa;
          cnt_hd_start <= r_hds;
          cnt_su_start <= r_sus;
          cnt_hd_data  <= r_hdd;
          cnt_su_data  <= r_sud;
          cnt_bus_free <= r_bf;
          cnt_su_stop  <= r_sto;
          done         <= 1'b1;
          busy         <= 1'b0;
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: an idle start makes the block busy on the next cycle
  a_r7_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7: results move only together with the completion pulse
  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt_high) || !$stable(cnt_bus_free)) |-> done);

  // R5: the high count never drops below the stretch-detection floor
  a_r5_high_floor: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_high >= NS_W'(HI_FLOOR)));

  // R6: hold ordering between data hold, start hold and bus free
  a_r6_hold_order: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_hd_data >= NS_W'(1) && cnt_hd_start > cnt_hd_data
              && cnt_bus_free > cnt_hd_data));

endmodule

// File: tb/test_i2c_timing_calc.sv
module test_i2c_timing_calc;

  localparam int W = 16;
  localparam int LAT = 12 * (W + 3) + 1;

  typedef struct packed {
    logic [W-1:0] hi, lo, ri, fa, hds, sus, hdd, sud, bf, sto;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] speed = '0;
  logic [W-1:0] tclk_ns = 16'd10, rise_ns = '0, fall_ns = '0, user_period_ns = '0;
  logic busy, done;
  logic [W-1:0] cnt_high, cnt_low, cnt_rise, cnt_fall, cnt_hd_start, cnt_su_start;
  logic [W-1:0] cnt_hd_data, cnt_su_data, cnt_bus_free, cnt_su_stop;

  int checks = 0;
  int errors = 0;
  int n_push = 0;
  int n_done = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  i2c_timing_calc #(.NS_W(W)) i_i2c_timing_calc (
    .clk(clk), .rst(rst), .start(start), .speed(speed), .tclk_ns(tclk_ns),
    .rise_ns(rise_ns), .fall_ns(fall_ns), .user_period_ns(user_period_ns),
    .busy(busy), .done(done), .cnt_high(cnt_high), .cnt_low(cnt_low),
    .cnt_rise(cnt_rise), .cnt_fall(cnt_fall), .cnt_hd_start(cnt_hd_start),
    .cnt_su_start(cnt_su_start), .cnt_hd_data(cnt_hd_data),
    .cnt_su_data(cnt_su_data), .cnt_bus_free(cnt_bus_free),
    .cnt_su_stop(cnt_su_stop)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // reference model built from the requirements (R1..R6)
  function automatic exp_t model(input int spd, input int tc, input int tr,
                                 input int tf, input int up);
    int m_hi, m_lo, m_hs, m_ss, m_hd, m_sd, m_bf, m_st, m_pr;
    int hdd, per, fl, sp;
    exp_t e;
    m_hd = 0;
    case (spd)
      1: begin m_hi=600; m_lo=1300; m_hs=600; m_ss=600; m_sd=100; m_bf=1300; m_st=600; m_pr=2500; end
      2: begin m_hi=260; m_lo=500; m_hs=260; m_ss=260; m_sd=50; m_bf=500; m_st=260; m_pr=1000; end
      default: begin m_hi=4000; m_lo=4700; m_hs=4000; m_ss=4700; m_sd=250; m_bf=4700; m_st=4000; m_pr=10000; end
    endcase
    hdd   = imax(cdiv(m_hd, tc), 1);
    per   = imax(cdiv(m_pr, tc), cdiv(up, tc));
    fl    = imax(cdiv(m_hi, tc), 4);
    e.lo  = W'(cdiv(m_lo, tc));
    e.ri  = W'(cdiv(tr, tc));
    e.fa  = W'(cdiv(tf, tc));
    sp    = per - cdiv(tr, tc) - cdiv(m_lo, tc) - cdiv(tf, tc);
    e.hi  = W'(imax(sp, fl));
    e.hdd = W'(hdd);
    e.hds = W'(imax(cdiv(m_hs, tc), hdd + 1));
    e.bf  = W'(imax(cdiv(m_bf, tc), hdd + 1));
    e.sus = W'(cdiv(m_ss, tc));
    e.sud = W'(cdiv(m_sd, tc));
    e.sto = W'(cdiv(m_st, tc));
    return e;
  endfunction

  // driver: wait for a slot, apply inputs, push the expected result
  task automatic run(input int spd, input int tc, input int tr, input int tf,
                     input int up, input bit b2b, input string tag);
    if (b2b) begin
      do @(negedge clk); while (!done);
    end else begin
      do @(negedge clk); while (busy);
    end
    speed = spd[1:0];
    tclk_ns = W'(tc);
    rise_ns = W'(tr);
    fall_ns = W'(tf);
    user_period_ns = W'(up);
    start = 1'b1;
    exp_q.push_back(model(spd, tc, tr, tf, up));
    tag_q.push_back(tag);
    n_push++;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: compare each completion against the head of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        n_done++;
        chk("R7 done width", int'(prev_done), 0);
        if (exp_q.size() == 0) begin
          chk("R8 unexpected result", 1, 0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " R4/R5 high"}, int'(cnt_high), int'(e.hi));
          chk({t, " R2 low"}, int'(cnt_low), int'(e.lo));
          chk({t, " R3 rise"}, int'(cnt_rise), int'(e.ri));
          chk({t, " R3 fall"}, int'(cnt_fall), int'(e.fa));
          chk({t, " R6 start hold"}, int'(cnt_hd_start), int'(e.hds));
          chk({t, " R2 start setup"}, int'(cnt_su_start), int'(e.sus));
          chk({t, " R6 data hold"}, int'(cnt_hd_data), int'(e.hdd));
          chk({t, " R2 data setup"}, int'(cnt_su_data), int'(e.sud));
          chk({t, " R6 bus free"}, int'(cnt_bus_free), int'(e.bf));
          chk({t, " R2 stop setup"}, int'(cnt_su_stop), int'(e.sto));
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_up();
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 high", int'(cnt_high), 0);
    chk("R10 bus free", int'(cnt_bus_free), 0);

    // R1 Fast-plus nominal bus, plus R11 latency and R7 busy
    run(2, 3, 120, 20, 0, 1'b0, "R1 fplus");
    chk("R7 busy after accept", int'(busy), 1);
    n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R11 latency", n, LAT);

    // R5 long rise forces the high floor
    run(2, 3, 400, 20, 0, 1'b0, "R5 slow rise");
    // R4 user period longer than the minimum, issued back to back (R9)
    run(0, 10, 1000, 300, 20000, 1'b1, "R9 R4 std user");
    run(1, 7, 300, 100, 0, 1'b1, "R9 fast");

    // R8: start while busy with other inputs is ignored
    run(1, 5, 200, 50, 3000, 1'b0, "R8 first");
    repeat (20) @(negedge clk);
    speed = 2'd0;
    tclk_ns = 16'd1;
    rise_ns = 16'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy kept", int'(busy), 1);

    // R1 reserved code behaves as Standard
    run(3, 20, 500, 100, 0, 1'b0, "R1 code3");
    // R5 high floor of 4 and R6 hold ordering with a coarse clock
    run(2, 200, 100, 10, 0, 1'b0, "R5 R6 coarse");
    run(2, 1000, 50, 10, 0, 1'b0, "R6 ordering");
    // R5 negative remainder must not wrap
    run(0, 10, 60000, 300, 0, 1'b0, "R5 no wrap");

    do @(negedge clk); while (busy || exp_q.size() != 0);
    repeat (300) @(negedge clk);
    chk("R8 result count", n_done, n_push);
    finish_up();
  end

endmodule